// File: doc/BRIEF.md
# CPU Bus Glue with USB FIFO Strobes and Interrupt Encoder

This block is the glue logic between a 68000-family processor with an 8-bit data bus and a 20-bit address bus and a byte-wide USB parallel FIFO bridge. It decodes each bus cycle into an active-low ROM select or an active-low RAM select. It also generates the two strobes that move single bytes through the bridge. Receive and transmit each appear as a wide address window whose low address bits are ignored. To the processor, a read or write of the bridge looks like an ordinary memory access.

The block also drives two active-low interrupt priority lines. A free-running counter raises a periodic timer request. The bridge's "byte available" flag raises a serial request, which is masked while the timer request is pending. During every interrupt acknowledge cycle, the block holds all selects inactive and requests an autovector, so no vector byte has to be placed on the data bus. The timer request is cleared by an acknowledge whose level matches the timer's level.

Top module: `bus_glue`

## Requirements
- R1: `ramSelN` is low exactly when `asN` is low, `fc` is not 3'b111 and `addr[19]` is 1 (addresses 0x80000–0xFFFFF).
- R2: `romSelN` is low exactly when `asN` is low, `fc` is not 3'b111, `addr[19]` is 0 and `addr[19:15]` is not 5'b01111 (addresses 0x00000–0x77FFF).
- R3: `bridgeRdN` is low exactly when `asN` is low, `fc` is not 3'b111, `rwN` is 1, `addr[19:15]` is 5'b01111 and `addr[14:13]` is 2'b00 (0x78000–0x79FFF). The values of `addr[12:0]` do not affect it.
- R4: `bridgeWr` is high exactly when `asN` is low, `fc` is not 3'b111, `rwN` is 0, `dsN` is low, `addr[19:15]` is 5'b01111 and `addr[14:13]` is 2'b01 (0x7A000–0x7BFFF). The values of `addr[12:0]` do not affect it.
- R5: Accesses to the device window with `addr[14:13]` equal to 2'b10 or 2'b11 (0x7C000–0x7FFFF) assert no select and no strobe. A read of the transmit window or a write to the receive window likewise asserts no strobe.
- R6: An interrupt acknowledge cycle is `asN` low with `fc` equal to 3'b111. During it, every select and strobe is inactive and `vpaN` is low. `vpaN` is high at all other times.
- R7: The timer request becomes pending on every TIMER_PERIOD-th rising clock edge after reset is released. While it is pending, `timerIrqN` is low. It stays pending until it is acknowledged.
- R8: An acknowledge cycle with `addr[3:1]` equal to TIMER_ACK_LEVEL (default 2) clears the pending timer request at that clock edge. An acknowledge at any other level leaves it pending. A timer period that ends on the same edge as the acknowledge wins.
- R9: `serialIrqN` is low exactly when `rxfN` is low and the timer request is not pending.
- R10: While `rstN` is low, the timer request is not pending and the period count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 20 | CPU address bus |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| rwN | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code; 3'b111 marks interrupt acknowledge |
| rxfN | input | 1 | Bridge receive byte available, active low |
| romSelN | output | 1 | ROM chip select, active low |
| ramSelN | output | 1 | RAM chip select, active low |
| bridgeRdN | output | 1 | Bridge read strobe, active low |
| bridgeWr | output | 1 | Bridge write strobe, active high |
| vpaN | output | 1 | Autovector request, active low |
| timerIrqN | output | 1 | Timer interrupt priority line, active low |
| serialIrqN | output | 1 | Serial receive interrupt priority line, active low |

## Verification
The bench probes the region edges: 0x77FFF/0x78000, 0x79FFF/0x7A000, 0x7BFFF/0x7C000 and 0x7FFFF/0x80000. A decoder off by one bit would leak a ROM select into the device window, or strobe the bridge at the unused offsets. It mixes read and write cycles with the data strobe both high and low across the windows. A write strobe that ignored the data strobe, or a read strobe that ignored direction, would pulse the bridge on the wrong cycles. It runs acknowledge cycles at every level while `asN` or `fc` vary. A design that let acknowledge cycles decode as memory would select ROM or RAM, and one that cleared the timer on the wrong level would drop the request too early. It holds `rxfN` low across timer periods, where failing to mask the serial line would show both priority lines low at once.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;

  // Decoded strobes handed from the decoder to the output/timer datapath
  typedef struct packed {
    logic romSel;
    logic ramSel;
    logic rxRead;
    logic txWrite;
    logic iack;
    logic timerAck;
  } glueStrobes_t;

  localparam logic [2:0] FcIack      = 3'b111;
  localparam logic [4:0] DevWindow   = 5'b01111;
  localparam logic [1:0] RxOffset    = 2'b00;
  localparam logic [1:0] TxOffset    = 2'b01;

endpackage

// File: rtl/bus_glue_decode.sv
module bus_glue_decode
  import bus_glue_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int TIMER_ACK_LEVEL = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rwN,
  input  logic [2:0]        fc,
  output glueStrobes_t      strobes
);

  localparam int TOP = ADDR_W - 1;

  logic memCycle;
  logic ackCycle;
  logic devHit;
  logic [1:0] devOffset;
  logic unusedAddr;

  assign ackCycle  = !asN && (fc == FcIack);
  assign memCycle  = !asN && (fc != FcIack);
  assign devHit    = (addr[TOP -: 5] == DevWindow);
  assign devOffset = addr[TOP-5 -: 2];
  assign unusedAddr = ^{addr[TOP-7:4], addr[0]};

  always_comb begin
    strobes          = '0;
    strobes.iack     = ackCycle;
    strobes.timerAck = ackCycle && (addr[3:1] == 3'(TIMER_ACK_LEVEL));
    if (memCycle) begin
      strobes.ramSel  = addr[TOP];
      strobes.romSel  = !addr[TOP] && !devHit;
      strobes.rxRead  = devHit && rwN && (devOffset == RxOffset);
      strobes.txWrite = devHit && !rwN && !dsN && (devOffset == TxOffset);
    end
  end

endmodule

// File: rtl/bus_glue_irq.sv
module bus_glue_irq
  import bus_glue_pkg::*;
#(
  parameter int TIMER_PERIOD = 2000
) (
  input  logic         clk,
  input  logic         rstN,
  input  glueStrobes_t strobes,
  input  logic         rxfN,
  output logic         romSelN,
  output logic         ramSelN,
  output logic         bridgeRdN,
  output logic         bridgeWr,
  output logic         vpaN,
  output logic         timerIrqN,
  output logic         serialIrqN
);

  localparam int CNT_W = (TIMER_PERIOD > 2) ? $clog2(TIMER_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMER_PERIOD - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             tick;
  logic             timerPending;

  assign tick = (tickCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tick) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerPending <= 1'b0;
    end else if (tick) begin
      timerPending <= 1'b1;
    end else if (strobes.timerAck) begin
      timerPending <= 1'b0;
    end
  end

  assign romSelN    = !strobes.romSel;
  assign ramSelN    = !strobes.ramSel;
  assign bridgeRdN  = !strobes.rxRead;
  assign bridgeWr   = strobes.txWrite;
  assign vpaN       = !strobes.iack;
  assign timerIrqN  = !timerPending;
  assign serialIrqN = !(!rxfN && !timerPending);

endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import bus_glue_pkg::*;
#(
  parameter int TIMER_PERIOD    = 2000,
  parameter int TIMER_ACK_LEVEL = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [19:0] addr,
  input  logic        asN,
  input  logic        dsN,
  input  logic        rwN,
  input  logic [2:0]  fc,
  input  logic        rxfN,
  output logic        romSelN,
  output logic        ramSelN,
  output logic        bridgeRdN,
  output logic        bridgeWr,
  output logic        vpaN,
  output logic        timerIrqN,
  output logic        serialIrqN
);

  glueStrobes_t strobes;

  bus_glue_decode #(
    .ADDR_W(20),
    .TIMER_ACK_LEVEL(TIMER_ACK_LEVEL)
  ) u_decode (
    .addr(addr),
    .asN(asN),
    .dsN(dsN),
    .rwN(rwN),
    .fc(fc),
    .strobes(strobes)
  );

  bus_glue_irq #(
    .TIMER_PERIOD(TIMER_PERIOD)
  ) u_irq (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .rxfN(rxfN),
    .romSelN(romSelN),
    .ramSelN(ramSelN),
    .bridgeRdN(bridgeRdN),
    .bridgeWr(bridgeWr),
    .vpaN(vpaN),
    .timerIrqN(timerIrqN),
    .serialIrqN(serialIrqN)
  );

endmodule

// File: rtl/bus_glue_chk.sv
module bus_glue_chk #(
  parameter int TIMER_ACK_LEVEL = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic [19:0] addr,
  input logic        asN,
  input logic        dsN,
  input logic        rwN,
  input logic [2:0]  fc,
  input logic        rxfN,
  input logic        romSelN,
  input logic        ramSelN,
  input logic        bridgeRdN,
  input logic        bridgeWr,
  input logic        vpaN,
  input logic        timerIrqN,
  input logic        serialIrqN
);

  logic ackNow;
  logic timerAckNow;
  logic unusedChk;

  assign ackNow      = !asN && (fc == 3'b111);
  assign timerAckNow = ackNow && (addr[3:1] == 3'(TIMER_ACK_LEVEL));
  assign unusedChk   = ^{addr[12:4], addr[0]};

  // R1
  ram_upper_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramSelN |-> (addr[19] && !asN));

  // R2
  rom_outside_dev_chk: assert property (@(posedge clk) disable iff (!rstN)
    !romSelN |-> (!addr[19] && addr[19:15] != 5'b01111));

  // R3
  rd_strobe_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bridgeRdN |-> (rwN && addr[14:13] == 2'b00 && !asN));

  // R4
  wr_needs_ds_chk: assert property (@(posedge clk) disable iff (!rstN)
    bridgeWr |-> (!dsN && !rwN && addr[14:13] == 2'b01));

  // R5
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!romSelN, !ramSelN, !bridgeRdN, bridgeWr}) <= 1);

  // R6
  iack_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackNow |-> (romSelN && ramSelN && bridgeRdN && !bridgeWr && !vpaN));

  // R7
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerIrqN && !timerAckNow) |=> !timerIrqN);

  // R9
  serial_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !timerIrqN |-> serialIrqN);

  // R9
  serial_follows_rxf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrqN && !rxfN) |-> !serialIrqN);

endmodule

bind bus_glue bus_glue_chk #(.TIMER_ACK_LEVEL(TIMER_ACK_LEVEL)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .dsN(dsN), .rwN(rwN),
  .fc(fc), .rxfN(rxfN), .romSelN(romSelN), .ramSelN(ramSelN),
  .bridgeRdN(bridgeRdN), .bridgeWr(bridgeWr), .vpaN(vpaN),
  .timerIrqN(timerIrqN), .serialIrqN(serialIrqN)
);

// File: tb/test_bus_glue.sv
`timescale 1ns/1ps
module test_bus_glue;

  localparam int PERIOD = 37;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addr = '0;
  logic        asN = 1'b1;
  logic        dsN = 1'b1;
  logic        rwN = 1'b1;
  logic [2:0]  fc = 3'b101;
  logic        rxfN = 1'b1;
  logic romSelN, ramSelN, bridgeRdN, bridgeWr, vpaN, timerIrqN, serialIrqN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  int edges = 0;
  bit mPending = 0;

  always #10 clk = ~clk;

  bus_glue #(.TIMER_PERIOD(PERIOD), .TIMER_ACK_LEVEL(2)) i_bus_glue (
    .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .dsN(dsN), .rwN(rwN),
    .fc(fc), .rxfN(rxfN), .romSelN(romSelN), .ramSelN(ramSelN),
    .bridgeRdN(bridgeRdN), .bridgeWr(bridgeWr), .vpaN(vpaN),
    .timerIrqN(timerIrqN), .serialIrqN(serialIrqN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b (addr=%h fc=%0d rw=%b ds=%b as=%b)",
               req, $time, act, exp, addr, fc, rwN, dsN, asN);
    end
  endtask

  // behavioural timer model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edges = 0;
      mPending = 0;
    end else begin
      edges++;
      if (edges % PERIOD == 0) mPending = 1;
      else if (!asN && fc == 3'b111 && addr[3:1] == 3'd2) mPending = 0;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit inBus, isAck, expRam, expRom, expRd, expWr;
      int a;
      a      = int'(addr);
      isAck  = !asN && fc == 3'b111;
      inBus  = !asN && !isAck;
      expRam = inBus && a >= 'h80000;
      expRom = inBus && a < 'h78000;
      expRd  = inBus && rwN && a >= 'h78000 && a < 'h7A000;
      expWr  = inBus && !rwN && !dsN && a >= 'h7A000 && a < 'h7C000;
      check("R1 ramSelN", ramSelN, !expRam);
      check("R2 romSelN", romSelN, !expRom);
      check("R3 bridgeRdN", bridgeRdN, !expRd);
      check("R4 bridgeWr", bridgeWr, expWr);
      check("R6 vpaN", vpaN, !isAck);
      check("R7 timerIrqN", timerIrqN, !mPending);
      check("R9 serialIrqN", serialIrqN, !(!rxfN && !mPending));
    end
  end

  task automatic drive(input logic [19:0] a, input logic as_n, input logic ds_n,
                       input logic rw_n, input logic [2:0] f, input logic rxf);
    @(posedge clk);
    #2;
    addr = a; asN = as_n; dsN = ds_n; rwN = rw_n; fc = f; rxfN = rxf;
  endtask

  initial begin
    logic [19:0] edgesList [10];
    edgesList = '{20'h00000, 20'h77FFF, 20'h78000, 20'h79FFF, 20'h7A000,
                  20'h7BFFF, 20'h7C000, 20'h7FFFF, 20'h80000, 20'hFFFFF};
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 timer idle in reset", timerIrqN, 1'b1);
    @(posedge clk); #2; rstN = 1'b1;

    // R1 R2 R3 R4 R5: boundary addresses, both directions and strobe states
    for (int i = 0; i < 10; i++)
      for (int m = 0; m < 4; m++)
        drive(edgesList[i], 1'b0, m[0], m[1], 3'b101, 1'b1);

    // R3 R4: low address bits ignored inside the windows
    for (int i = 0; i < 20; i++) begin
      drive(20'h78000 | 20'($urandom_range(0, 'h1FFF)), 1'b0, 1'b0, 1'b1, 3'b001, 1'b1);
      drive(20'h7A000 | 20'($urandom_range(0, 'h1FFF)), 1'b0, 1'b0, 1'b0, 3'b001, 1'b1);
    end

    // R5: unused device offsets, explicit check
    drive(20'h7C123, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1);
    @(negedge clk);
    check("R5 no write strobe at spare offset", bridgeWr, 1'b0);
    check("R5 no rom select at spare offset", romSelN, 1'b1);
    drive(20'h7E456, 1'b0, 1'b0, 1'b1, 3'b101, 1'b1);
    @(negedge clk);
    check("R5 no read strobe at spare offset", bridgeRdN, 1'b1);

    // R7 R8: wait for first tick, then acknowledge at a wrong level, then the right one
    rxfN = 1'b0;
    while (timerIrqN) @(negedge clk);
    check("R9 serial masked while timer pending", serialIrqN, 1'b1);
    drive(20'h00006, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0);   // level 3
    drive(20'h00000, 1'b1, 1'b1, 1'b1, 3'b101, 1'b0);
    @(negedge clk);
    check("R8 wrong-level ack keeps timer pending", timerIrqN, 1'b0);
    drive(20'h00004, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0);   // level 2
    drive(20'h00000, 1'b1, 1'b1, 1'b1, 3'b101, 1'b0);
    @(negedge clk);
    check("R8 level-2 ack clears timer", timerIrqN, 1'b1);
    check("R9 serial line follows rxf once timer cleared", serialIrqN, 1'b0);

    // mixed random traffic, including acknowledge cycles at all levels
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [19:0] a;
      sel = $urandom_range(0, 9);
      a = 20'($urandom);
      if (sel < 3) a = {5'b01111, a[14:0]};
      drive(a, ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom),
            (sel == 9) ? 3'b111 : 3'($urandom_range(0, 6)), 1'($urandom));
    end

    // R10: reset mid-run clears the pending request
    while (timerIrqN) @(negedge clk);
    #3 rstN = 1'b0;
    @(negedge clk);
    check("R10 reset clears pending timer", timerIrqN, 1'b1);
    @(posedge clk); #2; rstN = 1'b1;
    repeat (PERIOD + 2) drive(20'h12345, 1'b0, 1'b0, 1'b1, 3'b101, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule